// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns a core-side request into the pin-level timing of an 8-bit processor bus whose low address byte and data byte share the same pins. The core presents a cycle kind, a 16-bit address, write data and a flag that picks the long form of an opcode fetch. The sequencer then steps through T states. It drives the high address byte, the shared address/data byte with its output enable, an address-latch strobe, the read, write and interrupt-acknowledge strobes, and a three-bit cycle status. While a slow device holds READY low it adds wait states, and between cycles it hands the bus to another master.

A request is accepted while the sequencer is idle or halted, in the same clock that `req_ready` is high. At the end of T3 the core gets a one-cycle `done` pulse together with the byte sampled from the shared bus. The kind codes on `req_kind` are: 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write, 5 interrupt acknowledge, 6 bus idle, 7 halt. Reset is synchronous and active high.

Top module: `mbus_sequencer`

## Requirements
- R1: While `rst` is high, and whenever no machine cycle is in progress, `ad_oe`, `addr_hi_oe`, `ctl_oe` and `io_m_oe` are 0, `ale` is 0 and `s1`,`s0` are 0,0.
- R2: In T1, the first clock after a request is accepted, `ale` is 1 and `ad_oe` and `addr_hi_oe` are 1. `ad_out` carries address bits 7:0 and the read, write and acknowledge strobes are all high.
- R3: `io_m`,`s1`,`s0` are 0,1,1 for opcode fetch; 0,1,0 for memory read and bus idle; 0,0,1 for memory write; 1,1,0 for I/O read; 1,0,1 for I/O write; 1,1,1 for interrupt acknowledge. They are valid from T1 and unchanged until the cycle ends.
- R4: In T2, in every wait state and in T3, `rd_n` is low for opcode fetch, memory read and I/O read. `inta_n` is low instead of `rd_n` for interrupt acknowledge. `ad_oe` is 0 in those states.
- R5: In T2, in wait states and in T3 of a memory or I/O write, `wr_n` is low, `ad_oe` is 1 and `ad_out` carries the write data.
- R6: Memory read, memory write, I/O read, I/O write, interrupt acknowledge and bus idle take three T states without waits. An opcode fetch takes four T states, or six when `req_long` was 1. In T4 to T6, `addr_hi_oe` stays 1, `ad_oe` is 0 and no strobe is active.
- R7: `ready` is sampled at the end of T2 and at the end of each wait state. Each low sample adds one wait state, with the strobes held. A bus idle cycle ignores `ready`.
- R8: For an I/O read or write, `addr_hi` carries address bits 7:0, the same byte `ad_out` shows in T1. For all other kinds it carries bits 15:8.
- R9: `done` is 1 for exactly the one clock after T3. During that clock, `rdata` holds the `ad_in` value present during the last clock of T3.
- R10: `hold` is honoured only between cycles. `hlda` rises one clock after `hold` is seen while idle, and falls one clock after `hold` is seen low. While `hlda` is 1, `req_ready` is 0 and every output enable is 0.
- R11: A halt request enters a halted state with `s1`,`s0` at 0,0, `io_m_oe` at 0 and all buses floated. The halted state accepts the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| req_long | input | 1 | Opcode fetch uses six T states |
| req_ready | output | 1 | Request accepted this clock |
| done | output | 1 | One-clock pulse after T3 |
| rdata | output | 8 | Byte sampled at the end of T3 |
| ready | input | 1 | Device ready, low inserts wait states |
| hold | input | 1 | Other master requests the bus |
| hlda | output | 1 | Bus granted to the other master |
| addr_hi | output | 8 | High address byte |
| addr_hi_oe | output | 1 | Drive enable for addr_hi |
| ad_out | output | 8 | Shared address/data byte out |
| ad_in | input | 8 | Shared address/data byte in |
| ad_oe | output | 1 | Drive enable for ad_out |
| ale | output | 1 | Address latch strobe, always driven |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| ctl_oe | output | 1 | Drive enable for rd_n, wr_n, inta_n |
| io_m | output | 1 | I/O-versus-memory status |
| io_m_oe | output | 1 | Drive enable for io_m |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |

## Verification
On every clock, the assertions check the pin-level invariants. Nothing drives during reset, ALE coincides with a driven address and idle strobes, and at most one strobe is low. A read never drives the shared bus while a write always does. Status holds from T1 into T2. Under a bus grant every line floats, and the grant follows a hold request. Only the bench's scenarios can show the rest: the exact length of each cycle kind, one extra state per low READY sample, and the port byte copied onto the high address. They also cover the data returned with the done pulse and the deferral of a hold that arrives in mid-transfer.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int MB_DATA_W = 8;
    localparam int MB_ADDR_W = 2 * MB_DATA_W;

    typedef enum logic [2:0] {
        CK_FETCH   = 3'd0,
        CK_MRD     = 3'd1,
        CK_MWR     = 3'd2,
        CK_IORD    = 3'd3,
        CK_IOWR    = 3'd4,
        CK_INTACK  = 3'd5,
        CK_IDLEBUS = 3'd6,
        CK_HALT    = 3'd7
    } cyc_kind_t;

    typedef enum logic [3:0] {
        TS_IDLE, TS_T1, TS_T2, TS_TW, TS_T3,
        TS_T4, TS_T5, TS_T6, TS_HOLD, TS_HALT
    } tstate_t;

    typedef struct packed {
        logic io_m;
        logic s1;
        logic s0;
    } bus_status_t;

    typedef struct packed {
        cyc_kind_t              kind;
        logic [MB_ADDR_W-1:0]   addr;
        logic [MB_DATA_W-1:0]   wdata;
        logic                   longf;
    } bus_req_t;

    function automatic bus_status_t status_of(input cyc_kind_t k);
        case (k)
            CK_FETCH:   return '{1'b0, 1'b1, 1'b1};
            CK_MRD:     return '{1'b0, 1'b1, 1'b0};
            CK_MWR:     return '{1'b0, 1'b0, 1'b1};
            CK_IORD:    return '{1'b1, 1'b1, 1'b0};
            CK_IOWR:    return '{1'b1, 1'b0, 1'b1};
            CK_INTACK:  return '{1'b1, 1'b1, 1'b1};
            CK_IDLEBUS: return '{1'b0, 1'b1, 1'b0};
            default:    return '{1'b0, 1'b0, 1'b0};
        endcase
    endfunction

    function automatic logic is_io(input cyc_kind_t k);
        return (k == CK_IORD) || (k == CK_IOWR);
    endfunction

    function automatic logic is_write(input cyc_kind_t k);
        return (k == CK_MWR) || (k == CK_IOWR);
    endfunction

    function automatic logic is_plain_read(input cyc_kind_t k);
        return (k == CK_FETCH) || (k == CK_MRD) || (k == CK_IORD);
    endfunction

endpackage

// File: rtl/mbus_tstate.sv
module mbus_tstate
    import mbus_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  bus_req_t req,
    input  logic     ready,
    input  logic     hold,
    output tstate_t  state,
    output bus_req_t cur,
    output logic     req_ready
);

    logic waitable;
    assign waitable  = (cur.kind != CK_IDLEBUS);
    assign req_ready = !rst && !hold && (state == TS_IDLE || state == TS_HALT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TS_IDLE;
            cur   <= '0;
        end else begin
            case (state)
                TS_IDLE, TS_HALT: begin
                    if (hold) begin
                        state <= TS_HOLD;
                    end else if (req_valid) begin
                        cur   <= req;
                        state <= (req.kind == CK_HALT) ? TS_HALT : TS_T1;
                    end
                end
                TS_T1: state <= TS_T2;
                TS_T2: state <= (waitable && !ready) ? TS_TW : TS_T3;
                TS_TW: state <= ready ? TS_T3 : TS_TW;
                TS_T3: state <= (cur.kind == CK_FETCH) ? TS_T4 : TS_IDLE;
                TS_T4: state <= cur.longf ? TS_T5 : TS_IDLE;
                TS_T5: state <= TS_T6;
                TS_T6: state <= TS_IDLE;
                TS_HOLD: state <= hold ? TS_HOLD : TS_IDLE;
                default: state <= TS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mbus_drive.sv
module mbus_drive
    import mbus_pkg::*;
#(
    parameter int DATA_W = MB_DATA_W,
    parameter int ADDR_W = MB_ADDR_W
) (
    input  logic              rst,
    input  tstate_t           state,
    input  bus_req_t          cur,
    output logic              hlda,
    output logic [DATA_W-1:0] addr_hi,
    output logic              addr_hi_oe,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              inta_n,
    output logic              ctl_oe,
    output logic              io_m,
    output logic              io_m_oe,
    output logic              s1,
    output logic              s0
);

    logic        in_cycle, xfer, t1;
    bus_status_t st;

    always_comb begin
        t1       = (state == TS_T1);
        xfer     = (state == TS_T2) || (state == TS_TW) || (state == TS_T3);
        in_cycle = !rst && (t1 || xfer || state == TS_T4 ||
                            state == TS_T5 || state == TS_T6);
        st       = in_cycle ? status_of(cur.kind) : '0;

        hlda       = !rst && (state == TS_HOLD);
        addr_hi    = is_io(cur.kind) ? cur.addr[DATA_W-1:0] : cur.addr[ADDR_W-1:DATA_W];
        addr_hi_oe = in_cycle;
        ale        = !rst && t1;
        ad_oe      = !rst && (t1 || (xfer && is_write(cur.kind)));
        ad_out     = t1 ? cur.addr[DATA_W-1:0] : cur.wdata;
        rd_n       = !(in_cycle && xfer && is_plain_read(cur.kind));
        wr_n       = !(in_cycle && xfer && is_write(cur.kind));
        inta_n     = !(in_cycle && xfer && cur.kind == CK_INTACK);
        ctl_oe     = in_cycle;
        io_m       = st.io_m;
        io_m_oe    = in_cycle;
        s1         = st.s1;
        s0         = st.s0;
    end

endmodule

// File: rtl/mbus_capture.sv
module mbus_capture
    import mbus_pkg::*;
#(
    parameter int DATA_W = MB_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  tstate_t           state,
    input  logic [DATA_W-1:0] ad_in,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= (state == TS_T3);
            if (state == TS_T3) rdata <= ad_in;
        end
    end

endmodule

// File: rtl/mbus_sequencer.sv
module mbus_sequencer
    import mbus_pkg::*;
#(
    parameter int DATA_W = MB_DATA_W,
    parameter int ADDR_W = MB_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_long,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    input  logic              ready,
    input  logic              hold,
    output logic              hlda,
    output logic [DATA_W-1:0] addr_hi,
    output logic              addr_hi_oe,
    output logic [DATA_W-1:0] ad_out,
    input  logic [DATA_W-1:0] ad_in,
    output logic              ad_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              inta_n,
    output logic              ctl_oe,
    output logic              io_m,
    output logic              io_m_oe,
    output logic              s1,
    output logic              s0
);

    bus_req_t req, cur;
    tstate_t  state;

    always_comb begin
        req.kind  = cyc_kind_t'(req_kind);
        req.addr  = req_addr;
        req.wdata = req_wdata;
        req.longf = req_long;
    end

    mbus_tstate u_tstate (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req(req),
        .ready(ready), .hold(hold), .state(state), .cur(cur),
        .req_ready(req_ready)
    );

    mbus_drive #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_drive (
        .rst(rst), .state(state), .cur(cur), .hlda(hlda),
        .addr_hi(addr_hi), .addr_hi_oe(addr_hi_oe), .ad_out(ad_out),
        .ad_oe(ad_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .inta_n(inta_n), .ctl_oe(ctl_oe), .io_m(io_m),
        .io_m_oe(io_m_oe), .s1(s1), .s0(s0)
    );

    mbus_capture #(.DATA_W(DATA_W)) u_capture (
        .clk(clk), .rst(rst), .state(state), .ad_in(ad_in),
        .done(done), .rdata(rdata)
    );

endmodule

// File: rtl/mbus_sequencer_chk.sv
module mbus_sequencer_chk (
    input logic clk,
    input logic rst,
    input logic hold,
    input logic hlda,
    input logic addr_hi_oe,
    input logic ad_oe,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic inta_n,
    input logic ctl_oe,
    input logic io_m,
    input logic io_m_oe,
    input logic s1,
    input logic s0
);

    // R1
    always_comb begin
        if (rst) begin
            rst_float_chk: assert (!ad_oe && !addr_hi_oe && !ctl_oe && !io_m_oe && !ale);
        end
    end

    // R2
    ale_addr_chk: assert property (@(posedge clk) disable iff (rst)
        ale |-> (ad_oe && addr_hi_oe && rd_n && wr_n && inta_n));

    // R3
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ale |=> $stable({io_m, s1, s0}));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({~rd_n, ~wr_n, ~inta_n}));

    // R4
    read_float_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !inta_n) |-> !ad_oe);

    // R5
    write_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> ad_oe);

    // R10
    grant_float_chk: assert property (@(posedge clk) disable iff (rst)
        hlda |-> !(ad_oe || addr_hi_oe || ctl_oe || io_m_oe));

    // R10
    grant_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hlda) |-> $past(hold));

    // R11
    float_status_chk: assert property (@(posedge clk) disable iff (rst)
        !io_m_oe |-> (!s1 && !s0));

endmodule

bind mbus_sequencer mbus_sequencer_chk u_chk (
    .clk(clk), .rst(rst), .hold(hold), .hlda(hlda),
    .addr_hi_oe(addr_hi_oe), .ad_oe(ad_oe), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .ctl_oe(ctl_oe),
    .io_m(io_m), .io_m_oe(io_m_oe), .s1(s1), .s0(s0)
);

// File: tb/mbus_sequencer_test.sv
module mbus_sequencer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        req_long = 1'b0;
    logic        req_ready, done, hlda, addr_hi_oe, ad_oe, ale;
    logic        rd_n, wr_n, inta_n, ctl_oe, io_m, io_m_oe, s1, s0;
    logic [7:0]  rdata, addr_hi, ad_out;
    logic        ready = 1'b1;
    logic        hold = 1'b0;
    logic [7:0]  ad_in = 8'h0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    mbus_sequencer uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_long(req_long),
        .req_ready(req_ready), .done(done), .rdata(rdata), .ready(ready),
        .hold(hold), .hlda(hlda), .addr_hi(addr_hi), .addr_hi_oe(addr_hi_oe),
        .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .ctl_oe(ctl_oe),
        .io_m(io_m), .io_m_oe(io_m_oe), .s1(s1), .s0(s0)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_status(input int k);
        case (k)
            0: return 3'b011;
            1: return 3'b010;
            2: return 3'b001;
            3: return 3'b110;
            4: return 3'b101;
            5: return 3'b111;
            6: return 3'b010;
            default: return 3'b000;
        endcase
    endfunction

    task automatic chk_float(input string tag);
        chk({ad_oe, addr_hi_oe, ctl_oe, io_m_oe, ale, s1, s0} == 7'b0, tag,
            {ad_oe, addr_hi_oe, ctl_oe, io_m_oe, ale, s1, s0}, 0);
    endtask

    // strobe vector {rd_n, wr_n, inta_n}
    function automatic logic [2:0] exp_strobe(input int k);
        if (k == 0 || k == 1 || k == 3) return 3'b011;
        if (k == 2 || k == 4)           return 3'b101;
        if (k == 5)                     return 3'b110;
        return 3'b111;
    endfunction

    task automatic xfer_chk(input int k, input logic [7:0] wd, input string where);
        logic wr = (k == 2 || k == 4);
        chk({rd_n, wr_n, inta_n} == exp_strobe(k), {"R4 strobe ", where},
            {rd_n, wr_n, inta_n}, exp_strobe(k));
        if (wr) chk(ad_oe && ad_out == wd, {"R5 write data ", where}, {ad_oe, ad_out}, {1'b1, wd});
        else    chk(!ad_oe, {"R4 bus released ", where}, ad_oe, 0);
        chk({io_m, s1, s0} == exp_status(k), {"R3 status held ", where},
            {io_m, s1, s0}, exp_status(k));
    endtask

    task automatic do_cycle(input int k, input logic [15:0] a, input logic [7:0] wd,
                            input bit lng, input int nwait, input bit hold_mid);
        int nw = (k == 6) ? 0 : nwait;
        logic [7:0] pat = a[7:0] ^ 8'h5A;
        logic [7:0] ehi = (k == 3 || k == 4) ? a[7:0] : a[15:8];
        req_valid = 1; req_kind = 3'(k); req_addr = a; req_wdata = wd;
        req_long = lng; ready = 1;
        #1;
        chk(req_ready, "R10 request accepted when idle", req_ready, 1);
        @(negedge clk);
        req_valid = 0;
        chk(ale && ad_oe && addr_hi_oe && ad_out == a[7:0] && {rd_n, wr_n, inta_n} == 3'b111,
            "R2 T1 address phase", {ale, ad_oe, addr_hi_oe, ad_out}, {3'b111, a[7:0]});
        chk(addr_hi == ehi, "R8 high address byte", addr_hi, ehi);
        chk({io_m, s1, s0} == exp_status(k), "R3 status in T1", {io_m, s1, s0}, exp_status(k));
        if (hold_mid) hold = 1;
        @(negedge clk);
        xfer_chk(k, wd, "T2");
        if (hold_mid) chk(!hlda, "R10 no grant mid-cycle", hlda, 0);
        ready = (k == 6) ? 1'b0 : (nw == 0);
        for (int i = 1; i <= nw; i++) begin
            @(negedge clk);
            xfer_chk(k, wd, "wait state R7");
            ready = (i == nw);
        end
        @(negedge clk);
        xfer_chk(k, wd, "T3");
        chk(!done, "R9 no done before T3 ends", done, 0);
        ad_in = pat;
        ready = 1;
        @(negedge clk);
        chk(done && rdata == pat, "R9 done pulse and data", {done, rdata}, {1'b1, pat});
        if (k == 0) begin
            chk(addr_hi_oe && !ad_oe && {rd_n, wr_n, inta_n} == 3'b111, "R6 T4 shape",
                {addr_hi_oe, ad_oe, rd_n, wr_n, inta_n}, 5'b10111);
            if (lng) begin
                @(negedge clk);
                chk(addr_hi_oe && !done, "R6 T5 present", {addr_hi_oe, done}, 2'b10);
                @(negedge clk);
                chk(addr_hi_oe && !ad_oe, "R6 T6 present", {addr_hi_oe, ad_oe}, 2'b10);
            end
            @(negedge clk);
            chk(!done, "R9 done lasts one clock", done, 0);
        end
        chk_float("R6 cycle ended, R1 floated");
        chk(!hlda, "R10 no grant at cycle end", hlda, 0);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_float("R1 during reset");
        chk(!req_ready && !done && !hlda, "R1 reset outputs", {req_ready, done, hlda}, 0);
        rst = 0;
        @(negedge clk);
        chk_float("R1 idle after reset");

        for (int k = 0; k <= 6; k++)
            for (int w = 0; w <= 2; w++)
                for (int l = 0; l <= 1; l++)
                    do_cycle(k, 16'((k * 16'h1357) ^ (w * 16'h0841) ^ (l << 15) ^ 16'hA0C3),
                             8'(k * 37 + w * 11 + l), bit'(l), w, 1'b0);

        // hold while idle, request ignored during grant
        hold = 1; req_valid = 1; req_kind = 3'd1;
        #1;
        chk(!req_ready, "R10 request blocked by hold", req_ready, 0);
        @(negedge clk);
        chk(hlda, "R10 grant one clock after hold", hlda, 1);
        chk_float("R10 floated under grant");
        @(negedge clk);
        chk(hlda && !ale && !req_ready, "R10 grant held, no cycle started",
            {hlda, ale, req_ready}, 3'b100);
        req_valid = 0; hold = 0;
        @(negedge clk);
        chk(!hlda, "R10 grant drops one clock after release", hlda, 1'b0);

        // hold arriving mid-transfer
        do_cycle(1, 16'h4321, 8'h00, 1'b0, 1, 1'b1);
        @(negedge clk);
        chk(hlda, "R10 grant after transfer completes", hlda, 1);
        hold = 0;
        @(negedge clk);
        chk(!hlda, "R10 grant released", hlda, 0);

        // halt
        req_valid = 1; req_kind = 3'd7; req_addr = 16'h1111;
        @(negedge clk);
        req_valid = 0;
        chk_float("R11 halted bus floated, status 00");
        @(negedge clk);
        chk(req_ready && !ale, "R11 halt waits for request", {req_ready, ale}, 2'b10);
        do_cycle(2, 16'hBEEF, 8'h3C, 1'b0, 0, 1'b0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule